// File: doc/BRIEF.md
# Serial Register-Access Slave with Pulse-Counted Mode Entry

This block is the slave side of a four-wire serial control port. An external master uses it to read and write an 8-bit-addressed register bank that sits beside it. Out of reset the select pin is not yet a serial select. The block counts rising edges on it, and on the third one it switches into serial mode. It stays in that mode until a synchronous reset or a power-down request clears it.

In serial mode, a frame starts when select falls and ends when select rises. The first byte of a frame is a command. 0xD4 starts a write: the next byte sets the subaddress, and each byte after that is written to the bank at the current subaddress, which then advances by one. 0xD5 starts a read: the block returns bytes on MISO, starting at the subaddress left by an earlier write-command frame, and advances after each byte. Any other command makes the block ignore the rest of the frame.

SCLK, MOSI and select are resynchronized into the system clock domain. The system clock must therefore run at least four times faster than SCLK. The register bank is accessed through a write strobe, an address, write data and combinational read data.

Top module: `spi_regport`

## Requirements
- R1: After reset the block is not in serial mode. Any frame before the third select rising edge produces no write strobe and leaves miso_oe low. reg_addr reads 0x00 after reset.
- R2: Serial mode begins at the third rising edge of select counted since reset, and it stays on across any number of later frames.
- R3: A pulse on pwr_down, or a reset, leaves serial mode. Three new select rising edges are then needed before any frame has an effect.
- R4: MOSI is sampled on SCLK rising edges, most significant bit first. The first byte of each frame is the command: 0xD4 means write and 0xD5 means read.
- R5: In a write frame, the second byte loads the subaddress. Each later complete byte gives a one-cycle reg_we pulse, with reg_addr set to the current subaddress and reg_wdata set to the byte. The subaddress then increments.
- R6: The subaddress wraps from 0xFF to 0x00 during auto-increment, for both writes and reads.
- R7: In a frame whose command is 0xD5, each later byte is driven on MISO MSB first. Bits change after SCLK falling edges and are stable at the next rising edge. Data comes from the bank at the current subaddress, which increments after each byte.
- R8: miso_oe is high only in serial mode, while select is low, and after a 0xD5 command. It is low between frames.
- R9: A command byte other than 0xD4 or 0xD5 causes no write strobe for the rest of that frame.
- R10: When select rises in the middle of a byte, the partial byte is discarded. No write occurs for it.
- R11: The subaddress, visible on reg_addr, keeps its value between frames. An address-only write frame followed by a read frame therefore reads from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down request; leaves serial mode |
| sel_n | input | 1 | Active-low select; also the mode-entry pulse input |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial read data to the master |
| miso_oe | output | 1 | Output enable for miso (high-impedance when low) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Current subaddress to the register bank |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_rdata | input | 8 | Read data from the bank at reg_addr |

## Verification
The bench builds the block with the default three-pulse entry count and a two-stage synchronizer. With these values, entry on exactly the third select edge can be shown at the ports: two frames before that edge produce nothing. The bench drives SCLK at twelve system clocks per period, which is three times the minimum ratio, so the synchronizer latency leaves margin before each MISO sample. Subaddress runs that start at 0xFE and 0xFF reach the 8-bit wrap for writes and for reads.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_WRITE = 8'hD4;
    localparam byte_t CMD_READ  = 8'hD5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic sel;
        logic sck;
        logic mosi;
    } pins_t;

    typedef struct packed {
        logic sel_rise;
        logic sel_fall;
        logic sck_rise;
        logic sck_fall;
    } edges_t;

    localparam pins_t PINS_IDLE = '{sel: 1'b1, sck: 1'b0, mosi: 1'b0};

    function automatic phase_e phase_after_cmd(byte_t cmd);
        if (cmd == CMD_WRITE)     return PH_ADDR;
        else if (cmd == CMD_READ) return PH_RDATA;
        else                      return PH_SKIP;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_regport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  pins_t  raw,
    output pins_t  level,
    output edges_t edg
);
    localparam int DEPTH = STAGES + 1;

    pins_t chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= PINS_IDLE;
        else     chain[0] <= raw;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= PINS_IDLE;
            else     chain[g] <= chain[g-1];
        end
    end

    pins_t prev;
    assign level = chain[STAGES-1];
    assign prev  = chain[STAGES];

    always_comb begin
        edg.sel_rise = level.sel  & ~prev.sel;
        edg.sel_fall = ~level.sel & prev.sel;
        edg.sck_rise = level.sck  & ~prev.sck;
        edg.sck_fall = ~level.sck & prev.sck;
    end

endmodule

// File: rtl/spi_mode_latch.sv
module spi_mode_latch #(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic sel_rise,
    output logic mode_on
);
    localparam int CW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            seen    <= '0;
            mode_on <= 1'b0;
        end else if (!mode_on && sel_rise) begin
            if (seen == LAST) mode_on <= 1'b1;
            seen <= seen + 1'b1;
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regport_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mode_on,
    input  pins_t  level,
    input  edges_t edg,
    input  byte_t  reg_rdata,
    output logic   reg_we,
    output byte_t  reg_addr,
    output byte_t  reg_wdata,
    output logic   miso,
    output logic   miso_oe
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    phase_e                 ph;
    byte_t                  shreg;
    byte_t                  txreg;
    byte_t                  addr;
    byte_t                  wdata_q;
    logic [BIT_CNT_W-1:0]   bitcnt;
    logic                   we_q;
    logic                   load_pend;
    logic                   miso_q;
    byte_t                  rx_byte;

    assign rx_byte = {shreg[BYTE_W-2:0], level.mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            shreg     <= '0;
            txreg     <= '0;
            addr      <= '0;
            wdata_q   <= '0;
            bitcnt    <= '0;
            we_q      <= 1'b0;
            load_pend <= 1'b0;
            miso_q    <= 1'b0;
        end else begin
            we_q      <= 1'b0;
            load_pend <= 1'b0;
            if (we_q)      addr  <= addr + 1'b1;
            if (load_pend) txreg <= reg_rdata;

            if (!mode_on || level.sel) begin
                ph     <= PH_IDLE;
                bitcnt <= '0;
            end else if (ph == PH_IDLE) begin
                if (edg.sel_fall) begin
                    ph     <= PH_CMD;
                    bitcnt <= '0;
                end
            end else begin
                if (edg.sck_rise) begin
                    shreg  <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        unique case (ph)
                            PH_CMD: begin
                                ph <= phase_after_cmd(rx_byte);
                                if (phase_after_cmd(rx_byte) == PH_RDATA)
                                    load_pend <= 1'b1;
                            end
                            PH_ADDR: begin
                                addr <= rx_byte;
                                ph   <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                we_q    <= 1'b1;
                                wdata_q <= rx_byte;
                            end
                            PH_RDATA: begin
                                addr      <= addr + 1'b1;
                                load_pend <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (edg.sck_fall && ph == PH_RDATA) begin
                    if (bitcnt == '0) begin
                        miso_q <= txreg[BYTE_W-1];
                    end else begin
                        miso_q <= txreg[BYTE_W-2];
                        txreg  <= txreg << 1;
                    end
                end
            end
        end
    end

    assign reg_we    = we_q;
    assign reg_addr  = addr;
    assign reg_wdata = wdata_q;
    assign miso      = miso_q;
    assign miso_oe   = mode_on && !level.sel && (ph == PH_RDATA);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int ENTRY_PULSES = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    pins_t  raw_pins;
    pins_t  level;
    edges_t edg;
    logic   mode_on;
    logic   sel_rise;

    assign raw_pins = '{sel: sel_n, sck: sck, mosi: mosi};
    assign sel_rise = edg.sel_rise;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_pins),
        .level (level),
        .edg   (edg)
    );

    spi_mode_latch #(.PULSES(ENTRY_PULSES)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .sel_rise (sel_rise),
        .mode_on  (mode_on)
    );

    spi_frame_engine u_frame (
        .clk       (clk),
        .rst       (rst),
        .mode_on   (mode_on),
        .level     (level),
        .edg       (edg),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_down,
    input logic       mode_on,
    input logic       sel_rise,
    input logic       miso_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr
);
    // R1
    reset_leaves_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mode_on);

    // R2
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_on && !pwr_down) |=> mode_on);

    // R2
    mode_enter_on_sel_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_on) |-> $past(sel_rise));

    // R3
    pwr_down_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_down) |-> !mode_on);

    // R8
    oe_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> mode_on);

    // R5
    write_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> mode_on);

    // R6
    addr_step_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_addr == $past(reg_addr) + 8'd1));

endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .mode_on  (mode_on),
    .sel_rise (sel_rise),
    .miso_oe  (miso_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/tb_spi_regport.sv
module tb_spi_regport;

    localparam int HALF = 6;
    localparam int GAP  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_down = 1'b0;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic       reg_we;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    always #10 clk = ~clk;

    spi_regport dut (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .sel_n     (sel_n),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // bank seen by the design, and an independent expected image
    logic [7:0] bank  [256];
    logic [7:0] model [256];
    assign reg_rdata = bank[reg_addr];
    always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

    typedef struct { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q [$];

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of the write strobe against the model queue
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected write addr", reg_addr, -1);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(reg_addr == e.a, "R5", "write addr", reg_addr, e.a);
                chk(reg_wdata == e.d, "R5", "write data", reg_wdata, e.d);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit rd,
                        output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            tick(HALF);
            if (rd) begin
                rx[i] = miso;
                if (i == 7) chk(miso_oe == 1'b1, "R8", "oe in read phase", miso_oe, 1);
            end
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        sel_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_high();
        tick(HALF);
        sel_n = 1'b1;
        tick(GAP);
    endtask

    task automatic pulse();
        sel_n = 1'b0;
        tick(4);
        sel_n = 1'b1;
        tick(4);
    endtask

    // write frame: command, address, data; 'live' selects whether writes are expected
    task automatic write_frame(input logic [7:0] cmd, input logic [7:0] a,
                               input logic [7:0] d [], input bit live);
        logic [7:0] dummy;
        logic [7:0] p;
        p = a;
        sel_low();
        xfer(cmd, 8, 1'b0, dummy);
        xfer(a, 8, 1'b0, dummy);
        foreach (d[k]) begin
            if (live) begin
                exp_q.push_back('{a: p, d: d[k]});
                model[p] = d[k];
                p = p + 8'd1;
            end
            xfer(d[k], 8, 1'b0, dummy);
        end
        sel_high();
    endtask

    task automatic read_frame(input logic [7:0] a, input int n, input string req);
        logic [7:0] dummy;
        logic [7:0] got;
        logic [7:0] p;
        p = a;
        sel_low();
        xfer(8'hD5, 8, 1'b0, dummy);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, 1'b1, got);
            chk(got == model[p], req, "read byte", got, model[p]);
            p = p + 8'd1;
        end
        sel_high();
        chk(miso_oe == 1'b0, "R8", "oe after read frame", miso_oe, 0);
        chk(reg_addr == p, "R11", "addr after read", reg_addr, p);
    endtask

    task automatic queue_drained(input string req);
        chk(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d3 [];
        logic [7:0] d1 [];
        logic [7:0] dummy;
        for (int i = 0; i < 256; i++) begin
            bank[i]  = 8'(i) ^ 8'h5A;
            model[i] = 8'(i) ^ 8'h5A;
        end
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk(miso_oe == 1'b0, "R1", "oe at reset", miso_oe, 0);
        chk(reg_we == 1'b0, "R1", "we at reset", reg_we, 0);
        chk(reg_addr == 8'h00, "R1", "addr at reset", reg_addr, 0);

        // R1/R2: frames on pulses 1 and 3 must do nothing
        d3 = '{8'h11, 8'h22, 8'h33};
        cur_req = "R1";
        write_frame(8'hD4, 8'h20, d3, 1'b0);
        pulse();
        write_frame(8'hD4, 8'h20, d3, 1'b0);
        queue_drained("R1");
        chk(bank[8'h20] == model[8'h20], "R2", "no write before entry", bank[8'h20], model[8'h20]);

        // R4 R5: MSB-first write burst
        cur_req = "R5";
        d3 = '{8'h81, 8'h3C, 8'hE7};
        write_frame(8'hD4, 8'h10, d3, 1'b1);
        queue_drained("R4");
        chk(reg_addr == 8'h13, "R11", "addr after write", reg_addr, 8'h13);

        // R6: wrap on write
        d3 = '{8'hA1, 8'hB2, 8'hC3};
        write_frame(8'hD4, 8'hFE, d3, 1'b1);
        queue_drained("R6");
        chk(reg_addr == 8'h01, "R6", "addr after wrap", reg_addr, 8'h01);

        // R9: unknown command
        cur_req = "R9";
        write_frame(8'h5A, 8'h30, d3, 1'b0);
        queue_drained("R9");

        // R10: partial trailing byte
        cur_req = "R10";
        d1 = '{8'hAA};
        exp_q.push_back('{a: 8'h40, d: 8'hAA});
        model[8'h40] = 8'hAA;
        sel_low();
        xfer(8'hD4, 8, 1'b0, dummy);
        xfer(8'h40, 8, 1'b0, dummy);
        xfer(8'hAA, 8, 1'b0, dummy);
        xfer(8'hF0, 4, 1'b0, dummy);
        sel_high();
        queue_drained("R10");
        chk(reg_addr == 8'h41, "R10", "addr after partial", reg_addr, 8'h41);

        // R7 R11: address frame then read frame
        cur_req = "R7";
        d1 = new[0];
        write_frame(8'hD4, 8'h10, d1, 1'b1);
        chk(reg_addr == 8'h10, "R11", "addr held after addr frame", reg_addr, 8'h10);
        read_frame(8'h10, 3, "R7");

        // R6: read across the wrap
        write_frame(8'hD4, 8'hFF, d1, 1'b1);
        read_frame(8'hFF, 2, "R6");

        // R3: power-down leaves mode; re-entry needs three edges
        pwr_down = 1'b1;
        tick(2);
        pwr_down = 1'b0;
        tick(2);
        cur_req = "R3";
        d3 = '{8'h01, 8'h02, 8'h03};
        write_frame(8'hD4, 8'h50, d3, 1'b0);
        pulse();
        write_frame(8'hD4, 8'h50, d3, 1'b0);
        queue_drained("R3");
        cur_req = "R2";
        write_frame(8'hD4, 8'h50, d3, 1'b1);
        queue_drained("R2");
        read_frame_setup: begin
            write_frame(8'hD4, 8'h50, d1, 1'b1);
            read_frame(8'h50, 3, "R7");
        end

        // R3: reset leaves mode
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        chk(reg_addr == 8'h00, "R1", "addr after reset", reg_addr, 0);
        cur_req = "R3";
        write_frame(8'hD4, 8'h60, d3, 1'b0);
        queue_drained("R3");

        tick(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule